// File: doc/BRIEF.md
# Accordion Pipeline Zero Suppressor

The block accepts a parallel hit pattern of `N` channel bits and sends out, one per clock, only the channel addresses of the bits that are set. Channels with no hit produce nothing, so a sparse pattern drains in a few cycles and a full pattern drains in `N` cycles.

The pattern is loaded in one cycle into a chain of bypass registers, one per channel. Each register captures its own channel number. A register whose hit bit is clear is switched into a transparent path, so upstream data passes straight through it to its downstream neighbour in the same cycle. The chain therefore shrinks to the registers that hold hits. Each clock, the register at the output end presents its address, and every live register takes the value of the next live register upstream. A register that receives no valid data switches to bypass. No priority encoder scans the pattern.

A load is accepted only while `busy_o` is low. The output side has no backpressure: `valid_o` marks each address word, and `done_o` pulses once when the chain is empty.

Top module: `azs_top`

## Requirements
- R1: While `rst_ni` is low, `busy_o`, `valid_o` and `done_o` are all low.
- R2: A `load_i` pulse while `busy_o` is low is accepted, and `busy_o` is high in the following cycle.
- R3: `load_i` while `busy_o` is high has no effect: the words of the event in progress and its done timing are unchanged.
- R4: After an accepted load, `valid_o` is high in each of the consecutive cycles 1..P, where cycle 1 is the first cycle after the load edge and P is the number of set bits. `addr_o` carries the channel indices of the set bits in strictly ascending order, where bit i of `pattern_i` is channel i.
- R5: The number of words emitted for one event equals the number of set bits in the loaded pattern.
- R6: `done_o` is high for exactly one cycle per event, in cycle P+1.
- R7: An all-zero pattern emits no word, and `done_o` is high in cycle 1.
- R8: `valid_o` and `done_o` are never high together. `busy_o` is low in the cycle after `done_o`, and `valid_o` is low while `busy_o` is low.
- R9: A pattern with all `N` bits set emits every channel index from 0 to N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load request for `pattern_i` |
| pattern_i | input | N | Hit pattern; bit i is channel i |
| busy_o | output | 1 | An event is draining; loads are ignored |
| valid_o | output | 1 | `addr_o` carries a channel address |
| addr_o | output | $clog2(N) | Channel address of a hit |
| done_o | output | 1 | One-cycle pulse after the last word of an event |

## Verification
Patterns made from random words stay near half density. The harder cases are long runs of bypassed registers between two hits, and hits only at the ends of the chain, where data has to cross many transparent stages in one cycle. The stimulus ANDs several random words together to produce sparse patterns with wide gaps, and adds directed single-bit patterns at both ends, an all-zero pattern and an all-ones pattern. Extra load requests are driven in the middle of a drain to show that they are ignored.

// File: rtl/azs_pkg.sv
package azs_pkg;
  typedef enum logic {
    AZS_IDLE  = 1'b0,
    AZS_DRAIN = 1'b1
  } azs_state_e;

  function automatic int azs_addr_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/azs_stage.sv
module azs_stage #(
  parameter int AW  = 4,
  parameter int IDX = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          hit_i,
  input  logic          shift_i,
  input  logic          up_vld_i,
  input  logic [AW-1:0] up_addr_i,
  output logic          dn_vld_o,
  output logic [AW-1:0] dn_addr_o,
  output logic          byp_o
);
  localparam logic [AW-1:0] SELF_ADDR = AW'(IDX);

  logic          byp_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q  <= 1'b1;
      addr_q <= '0;
    end else if (load_i) begin
      byp_q  <= ~hit_i;
      addr_q <= SELF_ADDR;
    end else if (shift_i && !byp_q) begin
      // take next live word from upstream; go transparent when none is left
      byp_q  <= ~up_vld_i;
      addr_q <= up_addr_i;
    end
  end

  // transparent when bypassed
  assign dn_vld_o  = byp_q ? up_vld_i  : 1'b1;
  assign dn_addr_o = byp_q ? up_addr_i : addr_q;
  assign byp_o     = byp_q;
endmodule

// File: rtl/azs_chain.sv
module azs_chain #(
  parameter int N  = 16,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [N-1:0]  pattern_i,
  input  logic          shift_i,
  output logic          head_vld_o,
  output logic [AW-1:0] head_addr_o,
  output logic          empty_o
);
  logic [N:0]         link_vld;
  logic [AW-1:0]      link_addr [N+1];
  logic [N-1:0]       byp;

  assign link_vld[N]  = 1'b0;
  assign link_addr[N] = '0;

  for (genvar k = 0; k < N; k++) begin : g_stage
    azs_stage #(.AW(AW), .IDX(k)) i_stage (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .hit_i    (pattern_i[k]),
      .shift_i  (shift_i),
      .up_vld_i (link_vld[k+1]),
      .up_addr_i(link_addr[k+1]),
      .dn_vld_o (link_vld[k]),
      .dn_addr_o(link_addr[k]),
      .byp_o    (byp[k])
    );
  end

  assign head_vld_o  = link_vld[0];
  assign head_addr_o = link_addr[0];
  assign empty_o     = &byp;
endmodule

// File: rtl/azs_ctrl.sv
module azs_ctrl
  import azs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic empty_i,
  output logic load_go_o,
  output logic shift_o,
  output logic busy_o,
  output logic done_o
);
  azs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      AZS_IDLE:  if (load_i)  state_d = AZS_DRAIN;
      AZS_DRAIN: if (empty_i) state_d = AZS_IDLE;
      default:                state_d = AZS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= AZS_IDLE;
    else         state_q <= state_d;
  end

  assign load_go_o = load_i && (state_q == AZS_IDLE);
  assign shift_o   = (state_q == AZS_DRAIN);
  assign busy_o    = (state_q == AZS_DRAIN);
  assign done_o    = (state_q == AZS_DRAIN) && empty_i;
endmodule

// File: rtl/azs_top.sv
module azs_top #(
  parameter int N = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [N-1:0]                     pattern_i,
  output logic                             busy_o,
  output logic                             valid_o,
  output logic [azs_pkg::azs_addr_w(N)-1:0] addr_o,
  output logic                             done_o
);
  localparam int AW = azs_pkg::azs_addr_w(N);

  logic          load_go, shift, empty, busy;
  logic          head_vld;
  logic [AW-1:0] head_addr;

  azs_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .empty_i  (empty),
    .load_go_o(load_go),
    .shift_o  (shift),
    .busy_o   (busy),
    .done_o   (done_o)
  );

  azs_chain #(.N(N), .AW(AW)) i_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_go),
    .pattern_i  (pattern_i),
    .shift_i    (shift),
    .head_vld_o (head_vld),
    .head_addr_o(head_addr),
    .empty_o    (empty)
  );

  assign busy_o  = busy;
  assign valid_o = busy && head_vld;
  assign addr_o  = head_addr;
endmodule

// File: rtl/azs_chk.sv
module azs_chk #(
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic          busy_o,
  input logic          valid_o,
  input logic [AW-1:0] addr_o,
  input logic          done_o
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!busy_o && !valid_o && !done_o); // R1
    end
  end

  AST_LOAD_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !busy_o |=> busy_o); // R2

  AST_LOAD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o); // R3

  AST_ADDR_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) |-> addr_o > $past(addr_o)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_DONE_NOT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o); // R8

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R8

  AST_NO_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !valid_o); // R8
endmodule

bind azs_top azs_chk #(.AW(AW)) i_azs_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .busy_o (busy_o),
  .valid_o(valid_o),
  .addr_o (addr_o),
  .done_o (done_o)
);

// File: tb/test_azs_top.sv
module test_azs_top;
  localparam int N  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load;
  logic [N-1:0]  pattern;
  logic          busy, valid, done;
  logic [AW-1:0] addr;
  int            n_run = 0;
  int            n_fail = 0;

  always #5 clk = ~clk;

  azs_top #(.N(N)) i_azs_top (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .load_i   (load),
    .pattern_i(pattern),
    .busy_o   (busy),
    .valid_o  (valid),
    .addr_o   (addr),
    .done_o   (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int popc(input logic [N-1:0] p);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(p[i]);
    return c;
  endfunction

  function automatic int nth_hit(input logic [N-1:0] p, input int n);
    int c = 0;
    for (int i = 0; i < N; i++) begin
      if (p[i]) begin
        if (c == n) return i;
        c++;
      end
    end
    return -1;
  endfunction

  // one event: load p; poke drives an extra load with another pattern while busy
  task automatic run_event(input logic [N-1:0] p, input bit poke, input string req);
    int pc       = popc(p);
    int got      = 0;
    int done_at  = 0;
    int bad_ord  = 0;
    int bad_act  = 0;
    int bad_exp  = 0;
    int overlap  = 0;
    @(negedge clk);
    chk(busy == 1'b0, "R2", "busy before load", int'(busy), 0);
    load    = 1'b1;
    pattern = p;
    @(negedge clk);
    load = 1'b0;
    chk(busy == 1'b1, "R2", "busy after load", int'(busy), 1);
    for (int c = 1; c <= N + 3 && done_at == 0; c++) begin
      if (valid) begin
        if (c != got + 1 || addr != AW'(nth_hit(p, got))) begin
          if (bad_ord == 0) begin
            bad_act = int'(addr);
            bad_exp = nth_hit(p, got);
          end
          bad_ord++;
        end
        got++;
      end
      if (done) begin
        done_at = c;
        if (valid) overlap++;
      end
      if (poke && c == 1) begin
        load    = 1'b1;   // R3: ignored while busy
        pattern = ~p;
      end else begin
        load = 1'b0;
      end
      @(negedge clk);
    end
    load = 1'b0;
    chk(bad_ord == 0, poke ? "R3" : "R4", "address order", bad_act, bad_exp);
    chk(got == pc, req, "word count R5", got, pc);
    chk(done_at == pc + 1, (pc == 0) ? "R7" : "R6", "done cycle", done_at, pc + 1);
    chk(overlap == 0, "R8", "valid with done", overlap, 0);
    chk(busy == 1'b0 && done == 1'b0, "R8", "idle after done", int'({busy, done}), 0);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] rp;
    void'($urandom(32'd20061029));
    rst_n   = 1'b0;
    load    = 1'b0;
    pattern = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !valid && !done, "R1", "outputs in reset",
        int'({busy, valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !valid && !done, "R1", "outputs after reset",
        int'({busy, valid, done}), 0);

    run_event('0, 1'b0, "R7");
    run_event('1, 1'b0, "R9");
    run_event(16'h8001, 1'b0, "R5");
    run_event(16'h8000, 1'b0, "R5");
    run_event(16'h0001, 1'b0, "R5");
    run_event(16'hAAAA, 1'b0, "R4");
    run_event(16'h00F0, 1'b1, "R3");
    run_event('0, 1'b1, "R7");
    run_event('1, 1'b1, "R9");

    for (int i = 0; i < 60; i++) begin
      rp = N'($urandom);
      if (i % 3 == 1) rp = rp & N'($urandom) & N'($urandom);
      if (i % 3 == 2) rp = rp | N'($urandom);
      run_event(rp, 1'($urandom), "R5");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule